// File: doc/BRIEF.md
# Shared Transmit Buffer Pool Allocator

This block keeps the books for an on-chip transmit buffer pool that is shared by 32 channels. Each channel may own a slice of the pool, counted in buffer locations. The block holds the slice size of every channel and a count of the locations nobody owns. It does not move any data itself.

A host sends one command at a time on the request port. A command names a channel, a requested size and a flag that says the size is meant to be applied. When the flag is set, the block spends two busy cycles on it. In the first cycle it gives back everything the channel holds. In the second it tries to take the requested amount out of the free space. The request succeeds or fails as a whole. On failure the channel is left with nothing and a failure interrupt pulses. When the flag is clear and the size is zero, the command is a plain acknowledge that leaves all allocations alone, which is the form a transmit abort uses. When the flag is clear but the size is not zero, the command is malformed. It is dropped and an error pulse is raised.

The size of any channel can be read at any time through a combinational readout port, and the free count is always visible.

Top module: `txpool_alloc`

## Requirements
- R1: After reset every channel reads size 0, `free_cnt` equals the pool depth (64), and `busy`, `ack`, `fail_irq` and `bad_req` are 0.
- R2: A request with `req_size_vld`=1 accepted at clock edge E0 completes at edge E2, so `ack` is 1 for the one cycle after E2. On success `ack_ok`=1, the channel then reads the requested size, and `free_cnt` = old free + old channel size − requested size.
- R3: After an accepted request with `req_size_vld`=1, `busy` is 1 for exactly the two cycles after E0 and after E1. A request presented while `busy`=1 is ignored: it changes no allocation and produces no pulse.
- R4: If the requested size is larger than old free + old channel size, `fail_irq` and `ack` pulse together with `ack_ok`=0. The channel then holds 0, and `free_cnt` = old free + old channel size.
- R5: A request with `req_size_vld`=0 and `req_size`=0 pulses `ack` with `ack_ok`=1 in the cycle after acceptance. It never raises `busy` and changes no allocation.
- R6: A request with `req_size_vld`=0 and `req_size`≠0 is malformed. It pulses `bad_req` for one cycle after acceptance, produces no `ack`, never raises `busy`, and changes no allocation or free count.
- R7: The sum of all channel sizes plus `free_cnt` always equals the pool depth, and `free_cnt` never exceeds it.
- R8: A valid request for size 0 always succeeds and returns the channel's whole slice to the free count.
- R9: Because the old slice is released before allocation, a channel can be resized into its own former space even when `free_cnt` is 0.
- R10: `rd_size` shows the stored size of channel `rd_ch` in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command strobe, sampled when not busy |
| req_ch | input | 5 | Channel the command targets |
| req_size_vld | input | 1 | Set when `req_size` is to be applied |
| req_size | input | 6 | Requested slice size in locations |
| busy | output | 1 | High while a resize is in progress |
| ack | output | 1 | One-cycle pulse when a command completes |
| ack_ok | output | 1 | Qualifies `ack`: 1 = success |
| fail_irq | output | 1 | One-cycle pulse when an allocation fails |
| bad_req | output | 1 | One-cycle pulse for a malformed command |
| rd_ch | input | 5 | Channel selected for the size readout |
| rd_size | output | 6 | Current slice size of `rd_ch` |
| free_cnt | output | 7 | Unallocated locations in the pool |

## Verification
The bench targets the cases where the order of release and allocation matters. One is a channel that grows into its own former space while the pool is empty; a design that allocated before releasing would deny it. Another is a failing request from a channel that already held locations; a design that skipped the release on failure would leak those locations, so the free count would no longer balance the table. The bench also sends malformed and transmit-abort commands, and commands that arrive while the block is busy. A design that acted on any of these would change a size or emit a stray pulse that the scoreboard does not expect. A run of random commands against a reference model then checks that the sizes and the free count stay in balance.

// File: rtl/txpool_pkg.sv
package txpool_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RELEASE = 2'd1,
    ST_ALLOC   = 2'd2
  } alloc_state_t;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_RESIZE = 2'd1,
    CMD_KEEP   = 2'd2,
    CMD_BAD    = 2'd3
  } cmd_kind_t;

  // Free space once a channel's current slice has been handed back.
  function automatic int unsigned after_release(int unsigned free_now,
                                                int unsigned held);
    return free_now + held;
  endfunction

  // True when a request of 'want' locations can be carved out of 'avail'.
  function automatic bit fits(int unsigned want, int unsigned avail);
    return want <= avail;
  endfunction

endpackage

// File: rtl/txpool_cmd_decode.sv
module txpool_cmd_decode
  import txpool_pkg::*;
#(
  parameter int SIZE_W = 6
) (
  input  logic              idle,
  input  logic              req_valid,
  input  logic              req_size_vld,
  input  logic [SIZE_W-1:0] req_size,
  output cmd_kind_t         kind
);

  always_comb begin
    kind = CMD_NONE;
    if (idle && req_valid) begin
      if (req_size_vld)        kind = CMD_RESIZE;
      else if (req_size == '0) kind = CMD_KEEP;
      else                     kind = CMD_BAD;
    end
  end

endmodule

// File: rtl/txpool_size_table.sv
module txpool_size_table #(
  parameter int NUM_CH = 32,
  parameter int SIZE_W = 6,
  parameter int CH_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [SIZE_W-1:0]        wr_data,
  input  logic [CH_W-1:0]          ra_ch,
  output logic [SIZE_W-1:0]        ra_data,
  input  logic [CH_W-1:0]          rb_ch,
  output logic [SIZE_W-1:0]        rb_data,
  output logic [NUM_CH*SIZE_W-1:0] tbl_flat
);

  logic [SIZE_W-1:0] entry [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry[g] <= '0;
      else if (wr_en && (wr_ch == CH_W'(g)))
        entry[g] <= wr_data;
    end
    assign tbl_flat[g*SIZE_W +: SIZE_W] = entry[g];
  end

  assign ra_data = entry[ra_ch];
  assign rb_data = entry[rb_ch];

endmodule

// File: rtl/txpool_free_counter.sv
module txpool_free_counter #(
  parameter int POOL_DEPTH = 64,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [CNT_W-1:0] add_amt,
  input  logic             sub_en,
  input  logic [CNT_W-1:0] sub_amt,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W:0] FULL = (CNT_W+1)'(POOL_DEPTH);

  logic [CNT_W:0] sum_up;
  logic [CNT_W:0] next_cnt;

  always_comb begin
    sum_up   = {1'b0, count} + {1'b0, add_amt};
    next_cnt = {1'b0, count};
    if (add_en)
      next_cnt = (sum_up > FULL) ? FULL : sum_up;
    else if (sub_en && (sub_amt <= count))
      next_cnt = {1'b0, count - sub_amt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= CNT_W'(POOL_DEPTH);
    else        count <= next_cnt[CNT_W-1:0];
  end

endmodule

// File: rtl/txpool_alloc_fsm.sv
module txpool_alloc_fsm
  import txpool_pkg::*;
#(
  parameter int SIZE_W = 6,
  parameter int CH_W   = 5,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_kind_t         kind,
  input  logic [CH_W-1:0]   req_ch,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [SIZE_W-1:0] held_size,
  input  logic [CNT_W-1:0]  free_now,
  output alloc_state_t      state,
  output logic [CH_W-1:0]   cur_ch,
  output logic              tbl_wr_en,
  output logic [SIZE_W-1:0] tbl_wr_data,
  output logic              cnt_add_en,
  output logic [CNT_W-1:0]  cnt_add_amt,
  output logic              cnt_sub_en,
  output logic [CNT_W-1:0]  cnt_sub_amt,
  output logic              release_ev,
  output logic              grant_ev,
  output logic              deny_ev,
  output logic              busy,
  output logic              ack,
  output logic              ack_ok,
  output logic              fail_irq,
  output logic              bad_req
);

  logic [SIZE_W-1:0] cur_size;
  logic              room;

  assign room       = fits(32'(cur_size), 32'(free_now));
  assign release_ev = (state == ST_RELEASE);
  assign grant_ev   = (state == ST_ALLOC) && room;
  assign deny_ev    = (state == ST_ALLOC) && !room;

  assign tbl_wr_en   = release_ev || grant_ev;
  assign tbl_wr_data = grant_ev ? cur_size : '0;
  assign cnt_add_en  = release_ev;
  assign cnt_add_amt = CNT_W'(held_size);
  assign cnt_sub_en  = grant_ev;
  assign cnt_sub_amt = CNT_W'(cur_size);
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_ch   <= '0;
      cur_size <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (kind == CMD_RESIZE) begin
            state    <= ST_RELEASE;
            cur_ch   <= req_ch;
            cur_size <= req_size;
          end
        end
        ST_RELEASE: state <= ST_ALLOC;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      ack_ok   <= 1'b0;
      fail_irq <= 1'b0;
      bad_req  <= 1'b0;
    end else begin
      ack      <= grant_ev || deny_ev || (kind == CMD_KEEP);
      ack_ok   <= grant_ev || (kind == CMD_KEEP);
      fail_irq <= deny_ev;
      bad_req  <= (kind == CMD_BAD);
    end
  end

endmodule

// File: rtl/txpool_alloc.sv
module txpool_alloc
  import txpool_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int POOL_DEPTH = 64,
  parameter int SIZE_W     = 6,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int CNT_W     = $clog2(POOL_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_ch,
  input  logic              req_size_vld,
  input  logic [SIZE_W-1:0] req_size,
  output logic              busy,
  output logic              ack,
  output logic              ack_ok,
  output logic              fail_irq,
  output logic              bad_req,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [SIZE_W-1:0] rd_size,
  output logic [CNT_W-1:0]  free_cnt
);

  cmd_kind_t              kind;
  alloc_state_t           state;
  logic [CH_W-1:0]        cur_ch;
  logic                   tbl_wr_en;
  logic [SIZE_W-1:0]      tbl_wr_data;
  logic [SIZE_W-1:0]      held_size;
  logic                   cnt_add_en;
  logic [CNT_W-1:0]       cnt_add_amt;
  logic                   cnt_sub_en;
  logic [CNT_W-1:0]       cnt_sub_amt;
  logic                   release_ev;
  logic                   grant_ev;
  logic                   deny_ev;
  logic [NUM_CH*SIZE_W-1:0] tbl_flat;

  txpool_cmd_decode #(.SIZE_W(SIZE_W)) u_decode (
    .idle         (state == ST_IDLE),
    .req_valid    (req_valid),
    .req_size_vld (req_size_vld),
    .req_size     (req_size),
    .kind         (kind)
  );

  txpool_size_table #(.NUM_CH(NUM_CH), .SIZE_W(SIZE_W), .CH_W(CH_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_wr_en),
    .wr_ch    (cur_ch),
    .wr_data  (tbl_wr_data),
    .ra_ch    (rd_ch),
    .ra_data  (rd_size),
    .rb_ch    (cur_ch),
    .rb_data  (held_size),
    .tbl_flat (tbl_flat)
  );

  txpool_free_counter #(.POOL_DEPTH(POOL_DEPTH), .CNT_W(CNT_W)) u_free (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (cnt_add_en),
    .add_amt (cnt_add_amt),
    .sub_en  (cnt_sub_en),
    .sub_amt (cnt_sub_amt),
    .count   (free_cnt)
  );

  txpool_alloc_fsm #(.SIZE_W(SIZE_W), .CH_W(CH_W), .CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind        (kind),
    .req_ch      (req_ch),
    .req_size    (req_size),
    .held_size   (held_size),
    .free_now    (free_cnt),
    .state       (state),
    .cur_ch      (cur_ch),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wr_data (tbl_wr_data),
    .cnt_add_en  (cnt_add_en),
    .cnt_add_amt (cnt_add_amt),
    .cnt_sub_en  (cnt_sub_en),
    .cnt_sub_amt (cnt_sub_amt),
    .release_ev  (release_ev),
    .grant_ev    (grant_ev),
    .deny_ev     (deny_ev),
    .busy        (busy),
    .ack         (ack),
    .ack_ok      (ack_ok),
    .fail_irq    (fail_irq),
    .bad_req     (bad_req)
  );

endmodule

// File: rtl/txpool_alloc_chk.sv
module txpool_alloc_chk #(
  parameter int NUM_CH     = 32,
  parameter int POOL_DEPTH = 64,
  parameter int SIZE_W     = 6,
  parameter int CH_W       = 5,
  parameter int CNT_W      = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     ack,
  input logic                     ack_ok,
  input logic                     fail_irq,
  input logic                     bad_req,
  input logic                     release_ev,
  input logic                     grant_ev,
  input logic                     deny_ev,
  input logic [CH_W-1:0]          cur_ch,
  input logic [CNT_W-1:0]         free_cnt,
  input logic [NUM_CH*SIZE_W-1:0] tbl_flat
);

  function automatic int unsigned held_total(logic [NUM_CH*SIZE_W-1:0] t);
    int unsigned s = 0;
    for (int i = 0; i < NUM_CH; i++) s += 32'(t[i*SIZE_W +: SIZE_W]);
    return s;
  endfunction

  logic [SIZE_W-1:0] cur_slice;
  assign cur_slice = tbl_flat[cur_ch*SIZE_W +: SIZE_W];

  assert_conservation_R7: assert property (@(posedge clk) disable iff (!rst_n)
    held_total(tbl_flat) + 32'(free_cnt) == POOL_DEPTH);

  assert_free_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(free_cnt) <= POOL_DEPTH);

  assert_busy_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 !busy);

  assert_release_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> (grant_ev || deny_ev));

  assert_fail_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fail_irq |-> (ack && !ack_ok && cur_slice == '0));

  assert_bad_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |-> (!ack && !busy && $stable(free_cnt) && $stable(tbl_flat)));

endmodule

bind txpool_alloc txpool_alloc_chk #(
  .NUM_CH(NUM_CH), .POOL_DEPTH(POOL_DEPTH), .SIZE_W(SIZE_W),
  .CH_W(CH_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .ack        (ack),
  .ack_ok     (ack_ok),
  .fail_irq   (fail_irq),
  .bad_req    (bad_req),
  .release_ev (release_ev),
  .grant_ev   (grant_ev),
  .deny_ev    (deny_ev),
  .cur_ch     (cur_ch),
  .free_cnt   (free_cnt),
  .tbl_flat   (tbl_flat)
);

// File: tb/tb_txpool_alloc.sv
module tb_txpool_alloc;

  localparam int NCH  = 32;
  localparam int POOL = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [4:0] req_ch = '0;
  logic       req_size_vld = 1'b0;
  logic [5:0] req_size = '0;
  logic       busy, ack, ack_ok, fail_irq, bad_req;
  logic [4:0] rd_ch = '0;
  logic [5:0] rd_size;
  logic [6:0] free_cnt;

  txpool_alloc dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ch(req_ch),
    .req_size_vld(req_size_vld), .req_size(req_size), .busy(busy),
    .ack(ack), .ack_ok(ack_ok), .fail_irq(fail_irq), .bad_req(bad_req),
    .rd_ch(rd_ch), .rd_size(rd_size), .free_cnt(free_cnt)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int exp_tbl [NCH];
  int exp_free;
  // Expected result kinds: 0 = ack ok, 1 = denied, 2 = malformed.
  int    q_kind [$];
  string q_tag  [$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops an expected item for every completion pulse.
  always @(negedge clk) begin
    if (rst_n && (ack || bad_req)) begin
      int got;
      got = bad_req ? 2 : (ack_ok ? 0 : 1);
      if (q_kind.size() == 0) begin
        check("R3 unexpected completion pulse", got, -1);
      end else begin
        int    k;
        string t;
        k = q_kind.pop_front();
        t = q_tag.pop_front();
        check({t, " result kind"}, got, k);
        check({t, " fail_irq"}, int'(fail_irq), (k == 1) ? 1 : 0);
        check({t, " ack with bad_req"}, int'(ack && bad_req), 0);
      end
    end
  end

  task automatic check_chan(string tag, int ch);
    rd_ch = 5'(ch);
    #1;
    check({tag, " rd_size"}, int'(rd_size), exp_tbl[ch]);
    check({tag, " free_cnt"}, int'(free_cnt), exp_free);
  endtask

  // Driver: updates the model, pushes the expected result, drives the port.
  task automatic issue(string tag, int ch, bit vld, int size, bit intrude);
    int avail;
    if (vld) begin
      avail = exp_free + exp_tbl[ch];
      if (size <= avail) begin
        exp_tbl[ch] = size; exp_free = avail - size;
        q_kind.push_back(0);
      end else begin
        exp_tbl[ch] = 0; exp_free = avail;
        q_kind.push_back(1);
      end
    end else if (size == 0) q_kind.push_back(0);
    else                    q_kind.push_back(2);
    q_tag.push_back(tag);

    req_valid = 1'b1; req_ch = 5'(ch); req_size_vld = vld; req_size = 6'(size);
    @(negedge clk);
    req_valid = 1'b0;
    if (vld) begin
      check({tag, " R3 busy cycle 1"}, int'(busy), 1);
      if (intrude) begin
        req_valid = 1'b1; req_ch = 5'd11; req_size_vld = 1'b1; req_size = 6'd1;
      end
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " R3 busy cycle 2"}, int'(busy), 1);
      @(negedge clk);
      check({tag, " R3 busy released"}, int'(busy), 0);
    end else begin
      check({tag, " R5/R6 no busy"}, int'(busy), 0);
    end
    @(negedge clk);
    check_chan(tag, ch);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) exp_tbl[i] = 0;
    exp_free = POOL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 ack", int'(ack), 0);
    check("R1 fail_irq", int'(fail_irq), 0);
    check("R1 bad_req", int'(bad_req), 0);
    check("R1 free_cnt", int'(free_cnt), POOL);
    for (int c = 0; c < NCH; c += 7) check_chan("R1 channel empty", c);

    issue("R2 grant ch3=20",          3, 1'b1, 20, 1'b1);
    check_chan("R3 intruder ignored", 11);
    issue("R2 grant ch5=40",          5, 1'b1, 40, 1'b0);
    issue("R4 deny ch7=10",           7, 1'b1, 10, 1'b0);
    issue("R9 grow ch3 to 24",        3, 1'b1, 24, 1'b0);
    check("R9 pool empty", int'(free_cnt), 0);
    issue("R5 keep ch5",              5, 1'b0, 0,  1'b0);
    issue("R6 malformed ch5",         5, 1'b0, 7,  1'b0);
    issue("R8 release ch5",           5, 1'b1, 0,  1'b0);
    issue("R2 grant ch3=63",          3, 1'b1, 63, 1'b0);
    issue("R2 grant ch9=1",           9, 1'b1, 1,  1'b0);
    issue("R4 deny ch9 holding 1",    9, 1'b1, 5,  1'b0);
    issue("R8 release ch3",           3, 1'b1, 0,  1'b0);

    // R10 readout follows rd_ch combinationally
    for (int c = 0; c < NCH; c++) check_chan("R10 readout", c);

    // R7: random mix against the model
    for (int n = 0; n < 60; n++) begin
      int ch, sz, r;
      bit v;
      ch = int'($urandom_range(0, NCH - 1));
      sz = int'($urandom_range(0, 63));
      r  = int'($urandom_range(0, 9));
      v  = (r != 0);
      if (r == 0 && ($urandom_range(0, 1) == 0)) sz = 0;
      issue("R7 random", ch, v, sz, 1'b0);
    end
    for (int c = 0; c < NCH; c++) check_chan("R7 final table", c);

    repeat (2) @(negedge clk);
    check("R3 queue drained", q_kind.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule